// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

This block turns parallel audio samples into serial data lines for a stereo audio link. A clock generator outside the block supplies a one-cycle strobe for every falling edge of the bit clock, and a second strobe that marks the first bit of each 64-bit frame. The frame is made of two 32-bit slots, one for the left sample and one for the right sample. Before each slot starts, the block pulls one word per data line from a show-ahead transmit FIFO. It then drives that word out MSB first, with the position inside the slot set by the selected framing.

The framing can be standard I2S, left-justified or right-justified. Two short-pulse PCM modes are also available: one where data starts one bit after the frame pulse, and one where data starts in the same bit as the pulse. The valid sample width can be set from 1 to 32 bits inside the fixed slot. Up to four data lines run in parallel, one per channel pair, and lines above the programmed pair count stay low. Transmission is gated by a start bit. Once that bit is set, the block waits for the next frame boundary before it sends anything.

Top module: `tdm_serial_tx`

## Requirements
- R1: After reset, `sdata` is all zero and neither `sample_req` nor `underrun` is asserted.
- R2: Delayed framing (I2S, and PCM with `pcm_dly` = 0): each line carries the left-justified stream delayed by one bit clock, so the MSB appears in slot bit 1. With a 32-bit width, the LSB appears in bit 0 of the following slot.
- R3: Immediate framing (left-justified, and PCM with `pcm_dly` non-zero): the MSB of the sample appears in slot bit 0, and the next lower bits follow on each later bit clock.
- R4: Right-justified framing (`fmt_sel` = 2, `pcm_sel` = 0): the sample LSB is slot bit 31, and every slot bit before the first valid bit is 0.
- R5: Mode decode: with `pcm_sel` = 0, `fmt_sel` 0 is I2S, 1 is left-justified, 2 is right-justified and 3 behaves as I2S. `pcm_sel` = 1 overrides `fmt_sel`.
- R6: The valid width is `width_m1`+1 bits, taken from the low bits of each word. Word bits above that width are never sent, and slot bits outside the valid run are 0.
- R7: Data line `l` carries data only when `l` <= `pairs_m1`. Every other line stays 0.
- R8: `sample_req` is high for exactly one cycle per slot: the `bclk_fall` cycle that begins slot bit 0 (frame bits 0 and 32). `fifo_data[32*l +: 32]` is taken for line `l` in that same cycle.
- R9: If `fifo_empty` is high when `sample_req` is raised, `underrun` is high in that same cycle and the whole slot is sent as zeros on all lines.
- R10: While `tx_start` is low, `sdata` is 0 and no requests are made. After `tx_start` rises, the block stays idle until a `bclk_fall` that arrives together with `frame_start`.
- R11: Clearing `tx_start` forces `sdata` to 0 on the next clock and stops all further requests.
- R12: `sdata` is registered. It changes only in the clock after a `bclk_fall` strobe, and `frame_start` restarts the frame bit count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start | input | 1 | Transmit enable |
| fmt_sel | input | 2 | Framing select (0 I2S, 1 left, 2 right, 3 as I2S) |
| pcm_sel | input | 1 | Selects PCM short-pulse framing |
| pcm_dly | input | 2 | PCM data delay (0 one bit late, else immediate) |
| width_m1 | input | 5 | Valid sample width minus one |
| pairs_m1 | input | 2 | Active channel pairs minus one |
| bclk_fall | input | 1 | One-cycle strobe per bit-clock falling edge |
| frame_start | input | 1 | Marks the bit-clock strobe that begins a frame |
| fifo_empty | input | 1 | Transmit FIFO has no word |
| fifo_data | input | 32*LINES | Head FIFO word, 32 bits per line |
| sample_req | output | 1 | FIFO pop strobe, once per slot |
| underrun | output | 1 | Request made while the FIFO was empty |
| sdata | output | LINES | Serial data, one bit per line |

## Verification
The sample request and the underrun flag fall in the same clock: both are raised in the bit-clock strobe that opens a slot. The bench provokes this by holding the FIFO empty for exactly one slot of a frame. It then checks that `underrun` rises together with `sample_req` at that slot's first bit and at no other strobe. It also checks that the whole slot on every active line comes out as zeros, while the slots on either side carry their data. A second case puts a frame-start strobe on a slot boundary just after enable. The bench checks that this first strobe both arms the block and issues the request.

// File: rtl/tdm_serial_tx.sv
module tdm_serial_tx #(
  parameter int LINES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_start,
  input  logic [1:0]         fmt_sel,
  input  logic               pcm_sel,
  input  logic [1:0]         pcm_dly,
  input  logic [4:0]         width_m1,
  input  logic [1:0]         pairs_m1,
  input  logic               bclk_fall,
  input  logic               frame_start,
  input  logic               fifo_empty,
  input  logic [32*LINES-1:0] fifo_data,
  output logic               sample_req,
  output logic               underrun,
  output logic [LINES-1:0]   sdata
);

  localparam int SLOT  = 32;
  localparam int FRAME = 2 * SLOT;
  localparam int PW    = $clog2(FRAME);
  localparam int SB    = $clog2(SLOT);
  localparam int DW    = SLOT * LINES;

  logic [PW-1:0]    pos_q;
  logic [PW-1:0]    pos_n;
  logic             armed_q;
  logic [DW-1:0]    word_q;
  logic [DW-1:0]    word_now;
  logic [LINES-1:0] dly_q;
  logic [LINES-1:0] u;
  logic [SB-1:0]    p;
  logic [SB:0]      wid;

  wire go         = tx_start & bclk_fall & (armed_q | frame_start);
  assign pos_n    = frame_start ? '0 : pos_q + 1'b1;
  assign p        = pos_n[SB-1:0];
  wire slot_start = (p == '0);

  assign sample_req = go & slot_start;
  assign underrun   = sample_req & fifo_empty;

  wire delayed = pcm_sel ? (pcm_dly == 2'd0) : ((fmt_sel == 2'd0) || (fmt_sel == 2'd3));
  wire rjust   = !pcm_sel && (fmt_sel == 2'd2);

  assign word_now = slot_start ? (fifo_empty ? '0 : fifo_data) : word_q;
  assign wid      = {1'b0, width_m1} + 1'b1;

  wire          rj_hit = ({1'b0, p} + wid) >= (SB+1)'(SLOT);
  wire          lj_hit = (p <= width_m1);
  wire [SB-1:0] idx_rj = ~p;
  wire [SB-1:0] idx_lj = width_m1 - p;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    wire [SLOT-1:0] w = word_now[l*SLOT +: SLOT];
    wire active = (l <= int'(pairs_m1));
    assign u[l] = active & (rjust ? (rj_hit & w[idx_rj]) : (lj_hit & w[idx_lj]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= '0;
      armed_q <= 1'b0;
      word_q  <= '0;
      dly_q   <= '0;
      sdata   <= '0;
    end else if (!tx_start) begin
      armed_q <= 1'b0;
      dly_q   <= '0;
      sdata   <= '0;
    end else if (go) begin
      armed_q <= 1'b1;
      pos_q   <= pos_n;
      if (slot_start) word_q <= word_now;
      dly_q   <= u;
      sdata   <= delayed ? dly_q : u;
    end
  end

  assert_underrun_with_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> sample_req);

  assert_req_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_req |-> (bclk_fall && tx_start));

  assert_stop_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_start |=> (sdata == '0));

  assert_hold_between_strobes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !bclk_fall) |=> $stable(sdata));

  assert_no_req_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_start |-> !sample_req);

endmodule

// File: tb/tdm_serial_tx_tb.sv
module tdm_serial_tx_tb_top;
  localparam int CLK_P = 10;
  localparam int LINES = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic tx_start = 0;
  logic [1:0] fmt_sel = 0;
  logic pcm_sel = 0;
  logic [1:0] pcm_dly = 0;
  logic [4:0] width_m1 = 0;
  logic [1:0] pairs_m1 = 0;
  logic bclk_fall = 0;
  logic frame_start = 0;
  logic fifo_empty = 0;
  logic [32*LINES-1:0] fifo_data = '0;
  logic sample_req, underrun;
  logic [LINES-1:0] sdata;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  tdm_serial_tx #(.LINES(LINES)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .fmt_sel(fmt_sel),
    .pcm_sel(pcm_sel), .pcm_dly(pcm_dly), .width_m1(width_m1),
    .pairs_m1(pairs_m1), .bclk_fall(bclk_fall), .frame_start(frame_start),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .sample_req(sample_req),
    .underrun(underrun), .sdata(sdata)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, act=%0d exp<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] gen(input int s, input int l);
    return (32'h9E37_79B9 * (s + 1)) ^ (32'h0F1E_2D3C << l) ^ 32'h8000_0001;
  endfunction

  function automatic bit ubit(input bit rj, input int w, input logic [31:0] wrd, input int p);
    if (rj) return (p >= 32 - w) ? wrd[31 - p] : 1'b0;
    return (p < w) ? wrd[w - 1 - p] : 1'b0;
  endfunction

  // drive one bit-clock strobe; req/urn read in the strobe cycle, pre = sdata before the edge
  task automatic tick(input bit fs, output bit req, output bit urn, output logic [LINES-1:0] pre);
    @(negedge clk);
    bclk_fall = 1; frame_start = fs;
    #(CLK_P/4);
    req = sample_req; urn = underrun; pre = sdata;
    @(negedge clk);
    bclk_fall = 0; frame_start = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_stream(input logic [1:0] f, input bit pc, input logic [1:0] dl,
                            input int wm1, input int pm1, input int nbits,
                            input int empty_slot, input string tag);
    bit dlyd, rj, req, urn;
    logic [LINES-1:0] pre, expv, prev_u, prev_exp;
    int w;
    fmt_sel = f; pcm_sel = pc; pcm_dly = dl; width_m1 = 5'(wm1); pairs_m1 = 2'(pm1);
    tx_start = 1;
    dlyd = pc ? (dl == 0) : (f == 0 || f == 3);
    rj = !pc && f == 2;
    w = wm1 + 1;
    prev_u = '0; prev_exp = sdata;
    for (int k = 0; k < nbits; k++) begin
      int s = k / 32;
      int p = k % 32;
      bit emp = (s == empty_slot);
      fifo_empty = emp;
      for (int l = 0; l < LINES; l++) fifo_data[32*l +: 32] = gen(s, l);
      tick(k % 64 == 0, req, urn, pre);
      // R8: one request per slot at slot bit 0
      chk(req == (p == 0), "R8", $sformatf("sample_req at bit %0d", k), 64'(req), 64'(p == 0));
      // R9: underrun only with an empty FIFO at the request
      chk(urn == (p == 0 && emp), "R9", $sformatf("underrun at bit %0d", k), 64'(urn), 64'(p == 0 && emp));
      // R12: output still holds previous value before the clock edge
      chk(pre == prev_exp, "R12", $sformatf("pre-edge sdata at bit %0d", k), 64'(pre), 64'(prev_exp));
      for (int l = 0; l < LINES; l++) begin
        logic [31:0] wrd = emp ? 32'h0 : gen(s, l);
        bit ub = (l > pm1) ? 1'b0 : ubit(rj, w, wrd, p);
        expv[l] = dlyd ? prev_u[l] : ub;
        prev_u[l] = ub;
      end
      chk(sdata == expv, tag, $sformatf("sdata at frame bit %0d", k), 64'(sdata), 64'(expv));
      prev_exp = expv;
    end
    fifo_empty = 0;
  endtask

  task automatic stop_and_check(input string tag);
    bit req, urn;
    logic [LINES-1:0] pre;
    @(negedge clk);
    tx_start = 0;
    @(negedge clk);
    // R11: output forced low one clock after clear
    chk(sdata == '0, "R11", "sdata after stop", 64'(sdata), 64'h0);
    for (int k = 0; k < 40; k++) begin
      tick(k == 0, req, urn, pre);
      chk(!req && sdata == '0, "R11", $sformatf("%s idle strobe %0d", tag, k), {req, 59'(sdata)}, 64'h0);
    end
  endtask

  task automatic test_reset;
    // R1
    chk(sdata == '0, "R1", "sdata in reset", 64'(sdata), 64'h0);
    chk(!sample_req && !underrun, "R1", "req/underrun in reset", {sample_req, underrun}, 64'h0);
  endtask

  task automatic test_i2s;
    run_stream(2'd0, 0, 2'd0, 15, 0, 128, -1, "R2");   // R2 and R6 (16-bit in 32-bit slot)
    stop_and_check("i2s");
  endtask

  task automatic test_left;
    run_stream(2'd1, 0, 2'd0, 23, 1, 128, -1, "R3");   // R3, R7 two lines active
    stop_and_check("left");
  endtask

  task automatic test_right;
    run_stream(2'd2, 0, 2'd0, 15, 3, 128, -1, "R4");   // R4 all four lines
    run_stream(2'd2, 0, 2'd0, 31, 2, 64, -1, "R6");    // R6 full width
    stop_and_check("right");
  endtask

  task automatic test_modes;
    run_stream(2'd3, 0, 2'd0, 31, 0, 128, -1, "R5");   // R5 reserved code, R2 LSB spill
    stop_and_check("fmt3");
    run_stream(2'd2, 1, 2'd0, 31, 1, 128, -1, "R5");   // PCM delayed overrides fmt
    stop_and_check("pcm_a");
    run_stream(2'd0, 1, 2'd2, 19, 0, 128, -1, "R5");   // PCM immediate
    stop_and_check("pcm_b");
    run_stream(2'd1, 0, 2'd0, 0, 0, 64, -1, "R6");     // R6 one-bit width
    stop_and_check("w1");
  endtask

  task automatic test_underrun;
    run_stream(2'd1, 0, 2'd0, 31, 3, 128, 1, "R9");
    stop_and_check("urn");
  endtask

  task automatic test_start_gate;
    bit req, urn;
    logic [LINES-1:0] pre;
    fmt_sel = 2'd1; pairs_m1 = 2'd3; width_m1 = 5'd31;
    for (int l = 0; l < LINES; l++) fifo_data[32*l +: 32] = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      tick(k == 2, req, urn, pre);
      chk(!req && sdata == '0, "R10", "disabled strobe", {req, 59'(sdata)}, 64'h0);
    end
    tx_start = 1;
    for (int k = 0; k < 10; k++) begin
      tick(0, req, urn, pre);
      chk(!req && sdata == '0, "R10", "enabled, not armed", {req, 59'(sdata)}, 64'h0);
    end
    run_stream(2'd1, 0, 2'd0, 31, 3, 96, -1, "R10");
    run_stream(2'd1, 0, 2'd0, 31, 3, 64, -1, "R12");   // frame restart mid-frame
    stop_and_check("gate");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1;
    test_i2s();
    test_left();
    test_right();
    test_modes();
    test_underrun();
    test_start_gate();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule